// File: doc/BRIEF.md
# Constant Prefix Immediate Assembler

This block sits beside instruction decode and assembles the immediate operand for an instruction whose own 4-bit constant field is too narrow. A constant-prefix character placed ahead of that instruction carries twelve more constant bits. A size bit in the prefix selects the width of the result. When the size bit is clear, the twelve bits plus the consuming instruction's nibble form a 16-bit value that is sign-extended to 32 bits. When the size bit is set, the character fetched right after the prefix is raw constant data for bits 31:16 and is not an instruction.

Decode presents each fetched character on `instr_i` with `instr_valid_i`. It raises `consume_i` in the cycle it accepts that character. The block returns the immediate for the character now being presented. It flags whether that immediate came from a prefix, and whether the character is extension data to be skipped. It also holds interrupts off from the prefix through the instruction that uses the constant, so the sequence is never split. The wide constant is built from up to three characters with no pipeline stall.

Top module: `cpfx_imm_asm`

## Requirements
- R1: After a synchronous active-low reset, no prefix is pending: `ext_o`, `skip_o` are 0 and `irq_inhibit_o` is 0 unless the presented character is itself a prefix.
- R2: With no prefix pending, `imm_o` is `instr_i[3:0]` sign-extended to 32 bits (bit 3 copied into bits 31:4).
- R3: A character is a prefix when bits 15:13 equal 3'b100. Bit 12 is its size bit, and bits 11:0 become constant bits 15:4.
- R4: After a prefix with size bit 0 is taken, the next taken non-extension character sees `ext_o`=1 and `imm_o` = the sign extension of {prefix bits 11:0, `instr_i[3:0]`} from bit 15.
- R5: After a prefix with size bit 1 is taken, the next taken character supplies bits 31:16. The character after that sees `ext_o`=1 and `imm_o` = {extension character, prefix bits 11:0, `instr_i[3:0]`}.
- R6: While the extension character is expected, `skip_o` is 1. That character is never decoded as a prefix, even when its bits 15:13 are 3'b100.
- R7: `irq_inhibit_o` is 1 while a valid, non-extension prefix is presented. It stays 1 in every cycle until the consuming instruction is taken, that cycle included.
- R8: Taking a non-prefix, non-extension character clears the pending state, so the following character sees `ext_o`=0.
- R9: A prefix taken while another is pending replaces the pending constant bits and size.
- R10: A character is taken only when `instr_valid_i` and `consume_i` are both 1. Cycles with either low leave the state unchanged, so wait states between characters are tolerated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 16 | Fetched character presented to decode |
| instr_valid_i | input | 1 | `instr_i` holds a valid fetched character |
| consume_i | input | 1 | Decode accepts the presented character this cycle |
| imm_o | output | 32 | Immediate operand for the presented character |
| ext_o | output | 1 | `imm_o` is built from a pending prefix |
| skip_o | output | 1 | Presented character is constant data, not an instruction |
| irq_inhibit_o | output | 1 | Interrupts must not be taken this cycle |

## Verification
A wrong pending state shows at the ports in the cycle after the character that caused it is taken. A lost or extra prefix flips `ext_o` or `skip_o` and changes the upper bits of `imm_o` when the consuming instruction is presented. A corrupted stored constant field shows only in `imm_o` bits 31:4 of that consuming instruction. It therefore stays hidden until a prefix is followed by its user. The bench compares every output against its model on every cycle, including wait-state cycles where nothing is taken.

// File: rtl/cpfx_pkg.sv
// Package: shared encodings for the constant-prefix immediate assembler.
// Assumes a prefix is identified by a fixed opcode in the top bits of a character.
package cpfx_pkg;
    localparam int          CP_OPC_W = 3;
    localparam logic [2:0]  CP_OPC   = 3'b100;

    typedef enum logic [1:0] {
        CP_IDLE    = 2'd0,   // no constant pending
        CP_WAIT_HI = 2'd1,   // long prefix taken, extension character expected
        CP_HOLD    = 2'd2    // constant bits ready for the consuming instruction
    } cp_state_e;
endpackage

// File: rtl/cpfx_classify.sv
// Module: cpfx_classify
// Splits a fetched character into prefix flag, size bit, constant field and
// low nibble. Purely combinational; assumes the opcode sits in the top bits,
// the size bit directly below it and the constant field below that.
module cpfx_classify
    import cpfx_pkg::*;
#(
    parameter int CHAR_W = 16,
    parameter int NIB_W  = 4
) (
    input  logic [CHAR_W-1:0]               char_i,
    output logic                            is_pfx_o,
    output logic                            long_o,
    output logic [CHAR_W-CP_OPC_W-2:0]      field_o,
    output logic [NIB_W-1:0]                nib_o
);
    localparam int OPC_LSB  = CHAR_W - CP_OPC_W;
    localparam int SIZE_BIT = OPC_LSB - 1;

    // Decode the opcode, size bit and both constant fields.
    always_comb begin
        is_pfx_o = (char_i[CHAR_W-1:OPC_LSB] == CP_OPC);
        long_o   = char_i[SIZE_BIT];
        field_o  = char_i[SIZE_BIT-1:0];
        nib_o    = char_i[NIB_W-1:0];
    end
endmodule

// File: rtl/cpfx_track.sv
// Module: cpfx_track
// Holds the pending-prefix state, the stored constant field and the upper
// constant half. Advances only on a taken character (valid and consumed).
// Assumes the upper half of the immediate is exactly one character wide.
module cpfx_track
    import cpfx_pkg::*;
#(
    parameter int CHAR_W  = 16,
    parameter int FIELD_W = 12,
    parameter int HI_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take_i,
    input  logic                is_pfx_i,
    input  logic                long_i,
    input  logic [FIELD_W-1:0]  field_i,
    input  logic [CHAR_W-1:0]   char_i,
    output cp_state_e           state_o,
    output logic [FIELD_W-1:0]  lo_o,
    output logic [HI_W-1:0]     hi_o
);
    cp_state_e          state_q;
    logic [FIELD_W-1:0] lo_q;
    logic [HI_W-1:0]    hi_q;

    // Sequence prefix, optional extension character and consuming instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CP_IDLE;
            lo_q    <= '0;
            hi_q    <= '0;
        end else if (take_i) begin
            if (state_q == CP_WAIT_HI) begin
                hi_q    <= HI_W'(char_i);
                state_q <= CP_HOLD;
            end else if (is_pfx_i) begin
                lo_q <= field_i;
                if (long_i) begin
                    state_q <= CP_WAIT_HI;
                end else begin
                    hi_q    <= {HI_W{field_i[FIELD_W-1]}};
                    state_q <= CP_HOLD;
                end
            end else begin
                state_q <= CP_IDLE;
            end
        end
    end

    assign state_o = state_q;
    assign lo_o    = lo_q;
    assign hi_o    = hi_q;
endmodule

// File: rtl/cpfx_form.sv
// Module: cpfx_form
// Forms the immediate: prefix-built value when a constant is held, otherwise
// the character's own nibble sign-extended. Assumes HI_W+FIELD_W+NIB_W == IMM_W.
module cpfx_form
    import cpfx_pkg::*;
#(
    parameter int IMM_W   = 32,
    parameter int FIELD_W = 12,
    parameter int HI_W    = 16,
    parameter int NIB_W   = 4
) (
    input  cp_state_e           state_i,
    input  logic [FIELD_W-1:0]  lo_i,
    input  logic [HI_W-1:0]     hi_i,
    input  logic [NIB_W-1:0]    nib_i,
    output logic [IMM_W-1:0]    imm_o
);
    localparam int PAD_W = IMM_W - NIB_W;

    // Select between the assembled wide constant and the short immediate.
    always_comb begin
        if (state_i == CP_HOLD)
            imm_o = {hi_i, lo_i, nib_i};
        else
            imm_o = {{PAD_W{nib_i[NIB_W-1]}}, nib_i};
    end
endmodule

// File: rtl/cpfx_imm_asm.sv
// Module: cpfx_imm_asm (top)
// Builds a wide immediate from a constant-prefix character, an optional
// extension character and the consuming instruction's nibble, and holds
// interrupts off across the sequence. Assumes decode asserts consume_i only
// for the character it is accepting; a character counts only when valid.
module cpfx_imm_asm
    import cpfx_pkg::*;
#(
    parameter int CHAR_W = 16,
    parameter int IMM_W  = 32,
    parameter int NIB_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CHAR_W-1:0]   instr_i,
    input  logic                instr_valid_i,
    input  logic                consume_i,
    output logic [IMM_W-1:0]    imm_o,
    output logic                ext_o,
    output logic                skip_o,
    output logic                irq_inhibit_o
);
    localparam int FIELD_W = CHAR_W - CP_OPC_W - 1;
    localparam int HI_W    = IMM_W - FIELD_W - NIB_W;

    logic               take;
    logic               is_pfx;
    logic               long_sel;
    logic [FIELD_W-1:0] field;
    logic [NIB_W-1:0]   nib;
    cp_state_e          state;
    logic [FIELD_W-1:0] lo;
    logic [HI_W-1:0]    hi;

    // A character is taken only when fetched data is valid and accepted.
    assign take = instr_valid_i & consume_i;

    cpfx_classify #(.CHAR_W(CHAR_W), .NIB_W(NIB_W)) u_classify (
        .char_i   (instr_i),
        .is_pfx_o (is_pfx),
        .long_o   (long_sel),
        .field_o  (field),
        .nib_o    (nib)
    );

    cpfx_track #(.CHAR_W(CHAR_W), .FIELD_W(FIELD_W), .HI_W(HI_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_i   (take),
        .is_pfx_i (is_pfx),
        .long_i   (long_sel),
        .field_i  (field),
        .char_i   (instr_i),
        .state_o  (state),
        .lo_o     (lo),
        .hi_o     (hi)
    );

    cpfx_form #(.IMM_W(IMM_W), .FIELD_W(FIELD_W), .HI_W(HI_W), .NIB_W(NIB_W)) u_form (
        .state_i (state),
        .lo_i    (lo),
        .hi_i    (hi),
        .nib_i   (nib),
        .imm_o   (imm_o)
    );

    // Status flags and interrupt lockout from the prefix to its consumer.
    always_comb begin
        ext_o         = (state == CP_HOLD);
        skip_o        = (state == CP_WAIT_HI);
        irq_inhibit_o = (state != CP_IDLE) | (instr_valid_i & is_pfx & ~skip_o);
    end
endmodule

// File: rtl/cpfx_imm_asm_chk.sv
// Module: cpfx_imm_asm_chk
// Port-level properties of the constant-prefix immediate assembler, bound to the top.
module cpfx_imm_asm_chk #(
    parameter int CHAR_W = 16,
    parameter int IMM_W  = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [CHAR_W-1:0]   instr_i,
    input logic                instr_valid_i,
    input logic                consume_i,
    input logic [IMM_W-1:0]    imm_o,
    input logic                ext_o,
    input logic                skip_o,
    input logic                irq_inhibit_o
);
    logic taken;
    logic pfx_seen;
    assign taken    = instr_valid_i & consume_i;
    assign pfx_seen = (instr_i[CHAR_W-1 -: 3] == 3'b100);

    // R7
    pfx_locks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && pfx_seen && !skip_o) |=> irq_inhibit_o);

    // R7
    pending_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_o || skip_o) |-> irq_inhibit_o);

    // R5
    ext_char_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && skip_o) |=> (ext_o && !skip_o));

    // R8
    consumer_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !skip_o && !pfx_seen) |=> (!ext_o && !skip_o));

    // R10
    idle_cycle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |=> ($stable(ext_o) && $stable(skip_o)));

    // R2
    low_nibble_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        imm_o[3:0] == instr_i[3:0]);

    // R6
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ext_o, skip_o}));
endmodule

bind cpfx_imm_asm cpfx_imm_asm_chk #(.CHAR_W(CHAR_W), .IMM_W(IMM_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_i       (instr_i),
    .instr_valid_i (instr_valid_i),
    .consume_i     (consume_i),
    .imm_o         (imm_o),
    .ext_o         (ext_o),
    .skip_o        (skip_o),
    .irq_inhibit_o (irq_inhibit_o)
);

// File: tb/cpfx_imm_asm_tb.sv
module cpfx_imm_asm_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic        valid = 1'b0;
    logic        consume = 1'b0;
    logic [31:0] imm;
    logic        ext, skip, inh;

    int vectors = 0;
    int errors  = 0;

    // behavioural reference: 0 none pending, 1 awaiting upper half, 2 constant ready
    int          m_mode = 0;
    logic [11:0] m_lo = '0;
    logic [15:0] m_hi = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpfx_imm_asm dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_i       (instr),
        .instr_valid_i (valid),
        .consume_i     (consume),
        .imm_o         (imm),
        .ext_o         (ext),
        .skip_o        (skip),
        .irq_inhibit_o (inh)
    );

    task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // apply one cycle of stimulus, compare all outputs, then advance the model
    task automatic step(input string req, input logic r, input logic [15:0] c, input logic v, input logic k);
        logic        pfx;
        logic [31:0] e_imm;
        logic        e_inh;
        @(negedge clk);
        rst_n = r; instr = c; valid = v; consume = k;
        #1;
        pfx   = (c[15:13] == 3'b100);
        e_imm = (m_mode == 2) ? {m_hi, m_lo, c[3:0]} : {{28{c[3]}}, c[3:0]};
        e_inh = (m_mode != 0) || (v && pfx && m_mode != 1);
        if (r) begin
            cmp(req, "imm", imm, e_imm);
            cmp(req, "ext", {31'b0, ext}, {31'b0, m_mode == 2});
            cmp(req, "skip", {31'b0, skip}, {31'b0, m_mode == 1});
            cmp(req, "inhibit", {31'b0, inh}, {31'b0, e_inh});
        end
        @(posedge clk);
        if (!r) m_mode = 0;
        else if (v && k) begin
            if (m_mode == 1) begin m_hi = c; m_mode = 2; end
            else if (pfx) begin
                m_lo = c[11:0];
                if (c[12]) m_mode = 1;
                else begin m_hi = {16{c[11]}}; m_mode = 2; end
            end else m_mode = 0;
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (2) step("R1", 1'b0, 16'h0000, 1'b0, 1'b0);
        // R1: state after reset
        step("R1", 1'b1, 16'h1234, 1'b0, 1'b0);
        // R2: plain immediates, positive and negative nibble
        step("R2", 1'b1, 16'h1235, 1'b1, 1'b1);
        step("R2", 1'b1, 16'h123C, 1'b1, 1'b1);
        // R3 R4: short prefix, positive field
        step("R3", 1'b1, 16'h8123, 1'b1, 1'b1);
        step("R4", 1'b1, 16'h1117, 1'b1, 1'b1);
        step("R8", 1'b1, 16'h1117, 1'b1, 1'b1);
        // R4: short prefix with field bit 11 set sign-extends
        step("R4", 1'b1, 16'h8ABC, 1'b1, 1'b1);
        step("R4", 1'b1, 16'h3009, 1'b1, 1'b1);
        // R5: long prefix, extension, consumer
        step("R5", 1'b1, 16'h9456, 1'b1, 1'b1);
        step("R5", 1'b1, 16'hDEAD, 1'b1, 1'b1);
        step("R5", 1'b1, 16'h2002, 1'b1, 1'b1);
        // R6: extension char that looks like a prefix is data
        step("R6", 1'b1, 16'h9FFF, 1'b1, 1'b1);
        step("R6", 1'b1, 16'h8001, 1'b1, 1'b1);
        step("R6", 1'b1, 16'h1003, 1'b1, 1'b1);
        step("R8", 1'b1, 16'h1003, 1'b1, 1'b1);
        // R10: wait states between every character
        step("R10", 1'b1, 16'h9321, 1'b1, 1'b1);
        step("R10", 1'b1, 16'h5555, 1'b0, 1'b1);
        step("R10", 1'b1, 16'h5555, 1'b1, 1'b0);
        step("R10", 1'b1, 16'hBEEF, 1'b1, 1'b1);
        step("R10", 1'b1, 16'h8777, 1'b0, 1'b1);
        step("R7", 1'b1, 16'h1004, 1'b1, 1'b0);
        step("R7", 1'b1, 16'h1004, 1'b1, 1'b1);
        step("R7", 1'b1, 16'h8111, 1'b0, 1'b0);
        // R9: second prefix replaces the first
        step("R9", 1'b1, 16'h8FFF, 1'b1, 1'b1);
        step("R9", 1'b1, 16'h8123, 1'b1, 1'b1);
        step("R9", 1'b1, 16'h1006, 1'b1, 1'b1);
        step("R9", 1'b1, 16'h8456, 1'b1, 1'b1);
        step("R9", 1'b1, 16'h9789, 1'b1, 1'b1);
        step("R9", 1'b1, 16'hCAFE, 1'b1, 1'b1);
        step("R9", 1'b1, 16'h100F, 1'b1, 1'b1);
        // R1: reset while a long prefix is pending
        step("R1", 1'b1, 16'h9111, 1'b1, 1'b1);
        step("R1", 1'b0, 16'h0000, 1'b0, 1'b0);
        step("R1", 1'b1, 16'h1008, 1'b1, 1'b0);
        // mixed stream; top bits biased toward prefixes
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            logic [15:0] c;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            c = lfsr;
            if (lfsr[1:0] != 2'b00) c[15:13] = 3'b100;
            step("R10", 1'b1, c, lfsr[5] | lfsr[6], lfsr[7] | lfsr[8]);
        end
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule